// File: doc/BRIEF.md
# Address-to-Endpoint Partition Mapper

This block translates memory-mapped I/O addresses into partition endpoint numbers. It holds a table of entries. Each entry describes one naturally aligned, power-of-two sized window as a base and a mask, together with a rule for turning an address inside that window into an endpoint number. A lookup port accepts one address per cycle with a valid strobe. One cycle later it returns the endpoint number, a hit flag and a miss flag.

A configuration port writes a whole entry in one cycle. This covers enable, mode, base, mask, an endpoint or base-endpoint value and a segment-count selector. A second configuration port fills the per-segment endpoint list used by the individually mapped mode. The block checks every entry write against the rules of its mode. An illegal write is dropped and raises a sticky error flag, which only reset clears.

Top module: `pe_map_table`

## Requirements
- R1: An enabled entry matches address A when (A & mask) == (base & mask). A disabled entry never matches.
- R2: Mode 0 (single) maps every address in the window to the entry's programmed endpoint `cfg_pe`.
- R3: Mode 1 (full segmented) splits the window into PE_COUNT equal segments. The segment index is (A & ~mask) >> (log2(window size) - log2(PE_COUNT)), and segment n maps to endpoint n.
- R4: Mode 2 (individual) splits the window into IND_SEGS equal segments. Each segment returns the endpoint most recently written for it through the segment port (`cfg_seg_entry`, `cfg_seg_num`).
- R5: Mode 3 (offset) splits the window into 8, 64 or 128 segments, selected by `cfg_cnt_sel` = 0, 1 or 2. Segment n maps to endpoint `cfg_pe` + n.
- R6: A mode 3 write whose `cfg_pe` is not a multiple of the segment count is rejected and sets `cfg_err`. The flag stays set until reset.
- R7: A mode 0 write whose window is smaller than 2^25 bytes (32 MiB) is rejected and sets `cfg_err`.
- R8: The following writes are rejected and set `cfg_err`:
  - a mask whose ones are not contiguous from the top bit down;
  - a segmented-mode window smaller than its segment count;
  - `cfg_cnt_sel` = 3 in mode 3.
- R9: A rejected write leaves the addressed entry unchanged. A write with `cfg_en` = 0 is always accepted and disables the entry.
- R10: When several enabled entries match, the entry with the lowest index supplies the result.
- R11: When no entry matches, `rsp_miss` = 1, `rsp_hit` = 0 and `rsp_pe` is all ones. Otherwise `rsp_hit` = 1 and `rsp_miss` = 0.
- R12: `rsp_valid` rises exactly one cycle after `lk_valid` and is low otherwise. An entry written in one cycle is used by a lookup presented in the next cycle.
- R13: After reset every entry is disabled, `cfg_err` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_en | input | 1 | Enable bit for the written entry |
| cfg_mode | input | 2 | 0 single, 1 full segmented, 2 individual, 3 offset |
| cfg_base | input | ADDR_W | Window base |
| cfg_mask | input | ADDR_W | Window mask, contiguous high ones |
| cfg_pe | input | PE_W | Endpoint (mode 0) or base endpoint (mode 3) |
| cfg_cnt_sel | input | 2 | Mode 3 segment count: 0→8, 1→64, 2→128 |
| cfg_seg_we | input | 1 | Segment endpoint write strobe |
| cfg_seg_entry | input | IDX_W | Entry whose segment list is written |
| cfg_seg_num | input | IND_W | Segment number |
| cfg_seg_pe | input | PE_W | Endpoint for that segment |
| cfg_err | output | 1 | Sticky rejected-write flag |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | ADDR_W | Lookup address |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Some entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_pe | output | PE_W | Resulting endpoint, all ones on miss |

## Verification
The bench builds the block with its default parameters: 64-bit addresses, 256 endpoints, 16 entries and 8 individually mapped segments. With 256 endpoints, every segment of a full-segmented window can be swept, and every segment of each of the three offset counts, so all four modes are covered exhaustively against an arithmetic model kept in the bench. With 64-bit addresses, windows can be programmed just below and at the 32 MiB single-mode floor. With 16 entries, overlapping windows can be set up to exercise the priority rule. Each rejection case is run from a fresh reset, so that its own effect on the sticky flag can be seen.

// File: rtl/pe_map_pkg.sv
// Shared definitions for the address-to-endpoint mapper.
// Assumes the 2-bit mode encoding is fixed by the configuration port.
package pe_map_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_FULL   = 2'd1,
        MODE_INDIV  = 2'd2,
        MODE_OFFSET = 2'd3
    } map_mode_e;
endpackage

// File: rtl/pe_map_cfg_check.sv
// Validates one entry write and derives the segment shift for it.
// Assumes PE_COUNT and IND_SEGS are powers of two, with IND_SEGS >= 2.
module pe_map_cfg_check
    import pe_map_pkg::*;
#(
    parameter int ADDR_W          = 64,
    parameter int PE_COUNT        = 256,
    parameter int IND_SEGS        = 8,
    parameter int MIN_SINGLE_LOG2 = 25,
    localparam int PE_W  = $clog2(PE_COUNT),
    localparam int IND_W = $clog2(IND_SEGS),
    localparam int SH_W  = $clog2(ADDR_W) + 1
) (
    input  map_mode_e         mode,
    input  logic [ADDR_W-1:0] mask,
    input  logic [PE_W-1:0]   pe,
    input  logic [1:0]        cnt_sel,
    output logic              legal,
    output logic [SH_W-1:0]   shift
);
    logic [ADDR_W-1:0] inv;
    logic              contig;
    logic [SH_W-1:0]   size_log;
    logic [SH_W-1:0]   seg_log;
    logic              sel_ok;
    logic              base_ok;

    // Window size: the inverted mask must be of the form 2^k - 1.
    always_comb begin
        inv      = ~mask;
        contig   = ((inv & (inv + 1'b1)) == '0);
        size_log = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            size_log = size_log + SH_W'(inv[b]);
        end
    end

    // Number of segments (as a log2) requested by the mode.
    always_comb begin
        sel_ok = 1'b1;
        unique case (mode)
            MODE_SINGLE: seg_log = '0;
            MODE_FULL:   seg_log = SH_W'(PE_W);
            MODE_INDIV:  seg_log = SH_W'(IND_W);
            default: begin
                unique case (cnt_sel)
                    2'd0:    seg_log = SH_W'(3);
                    2'd1:    seg_log = SH_W'(6);
                    2'd2:    seg_log = SH_W'(7);
                    default: begin
                        seg_log = '0;
                        sel_ok  = 1'b0;
                    end
                endcase
            end
        endcase
    end

    // Offset mode: base endpoint must have zeros below the segment count.
    always_comb begin
        base_ok = 1'b1;
        for (int b = 0; b < PE_W; b++) begin
            if ((SH_W'(b) < seg_log) && pe[b]) base_ok = 1'b0;
        end
    end

    // Combine the per-mode rules into one verdict and the index shift.
    always_comb begin
        legal = contig && (size_log >= seg_log);
        if (mode == MODE_SINGLE && size_log < SH_W'(MIN_SINGLE_LOG2)) legal = 1'b0;
        if (mode == MODE_OFFSET && !(sel_ok && base_ok))             legal = 1'b0;
        shift = size_log - seg_log;
    end
endmodule

// File: rtl/pe_map_entry_match.sv
// Matches one table entry against an address and forms its endpoint.
// Assumes the stored shift leaves a segment index below the mode's count.
module pe_map_entry_match
    import pe_map_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PE_COUNT = 256,
    parameter int IND_SEGS = 8,
    localparam int PE_W  = $clog2(PE_COUNT),
    localparam int IND_W = $clog2(IND_SEGS),
    localparam int SH_W  = $clog2(ADDR_W) + 1
) (
    input  logic                             en,
    input  map_mode_e                        mode,
    input  logic [ADDR_W-1:0]                base,
    input  logic [ADDR_W-1:0]                mask,
    input  logic [PE_W-1:0]                  pe,
    input  logic [SH_W-1:0]                  shift,
    input  logic [IND_SEGS-1:0][PE_W-1:0]    seg_row,
    input  logic [ADDR_W-1:0]                addr,
    output logic                             hit,
    output logic [PE_W-1:0]                  pe_out
);
    logic [PE_W-1:0]  seg_idx;
    logic [IND_W-1:0] seg_ind;

    // Window compare on the masked bits only.
    always_comb hit = en && ((addr & mask) == (base & mask));

    // Segment index from the offset inside the window.
    always_comb begin
        seg_idx = PE_W'((addr & ~mask) >> shift);
        seg_ind = IND_W'((addr & ~mask) >> shift);
    end

    // Endpoint selection per mode.
    always_comb begin
        unique case (mode)
            MODE_SINGLE: pe_out = pe;
            MODE_FULL:   pe_out = seg_idx;
            MODE_INDIV:  pe_out = seg_row[seg_ind];
            default:     pe_out = pe + seg_idx;
        endcase
    end
endmodule

// File: rtl/pe_map_prio.sv
// Picks the lowest-numbered hitting entry; all ones when none hits.
// Assumes hits and endpoints arrive in entry order.
module pe_map_prio #(
    parameter int ENTRIES = 16,
    parameter int PE_W    = 8
) (
    input  logic [ENTRIES-1:0]           hits,
    input  logic [ENTRIES-1:0][PE_W-1:0] pes,
    output logic                         any,
    output logic [PE_W-1:0]              pe_sel
);
    // Scan from the top so the lowest index is assigned last.
    always_comb begin
        any    = 1'b0;
        pe_sel = '1;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any    = 1'b1;
                pe_sel = pes[i];
            end
        end
    end
endmodule

// File: rtl/pe_map_table.sv
// Programmable address-to-endpoint mapping table with a registered lookup.
// Assumes one entry write and one segment write at most per cycle;
// writes are seen by lookups presented on the next cycle.
module pe_map_table
    import pe_map_pkg::*;
#(
    parameter int ADDR_W          = 64,
    parameter int PE_COUNT        = 256,
    parameter int ENTRIES         = 16,
    parameter int IND_SEGS        = 8,
    parameter int MIN_SINGLE_LOG2 = 25,
    localparam int PE_W  = $clog2(PE_COUNT),
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int IND_W = $clog2(IND_SEGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [PE_W-1:0]   cfg_pe,
    input  logic [1:0]        cfg_cnt_sel,
    input  logic              cfg_seg_we,
    input  logic [IDX_W-1:0]  cfg_seg_entry,
    input  logic [IND_W-1:0]  cfg_seg_num,
    input  logic [PE_W-1:0]   cfg_seg_pe,
    output logic              cfg_err,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PE_W-1:0]   rsp_pe
);
    localparam int SH_W = $clog2(ADDR_W) + 1;

    logic                          ent_en    [ENTRIES];
    map_mode_e                     ent_mode  [ENTRIES];
    logic [ADDR_W-1:0]             ent_base  [ENTRIES];
    logic [ADDR_W-1:0]             ent_mask  [ENTRIES];
    logic [PE_W-1:0]               ent_pe    [ENTRIES];
    logic [SH_W-1:0]               ent_shift [ENTRIES];
    logic [IND_SEGS-1:0][PE_W-1:0] seg_pe    [ENTRIES];

    map_mode_e                     wr_mode;
    logic                          wr_legal;
    logic [SH_W-1:0]               wr_shift;
    logic                          wr_accept;

    logic [ENTRIES-1:0]            hits;
    logic [ENTRIES-1:0][PE_W-1:0]  pes;
    logic                          any_hit;
    logic [PE_W-1:0]               pe_sel;

    always_comb wr_mode = map_mode_e'(cfg_mode);

    pe_map_cfg_check #(
        .ADDR_W(ADDR_W), .PE_COUNT(PE_COUNT), .IND_SEGS(IND_SEGS),
        .MIN_SINGLE_LOG2(MIN_SINGLE_LOG2)
    ) u_check (
        .mode(wr_mode), .mask(cfg_mask), .pe(cfg_pe), .cnt_sel(cfg_cnt_sel),
        .legal(wr_legal), .shift(wr_shift)
    );

    // Disabling writes skip the legality rules.
    always_comb wr_accept = !cfg_en || wr_legal;

    // Entry storage and the sticky rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_en[i]    <= 1'b0;
                ent_mode[i]  <= MODE_SINGLE;
                ent_base[i]  <= '0;
                ent_mask[i]  <= '0;
                ent_pe[i]    <= '0;
                ent_shift[i] <= '0;
            end
        end else if (cfg_we) begin
            if (wr_accept) begin
                ent_en[cfg_idx]    <= cfg_en;
                ent_mode[cfg_idx]  <= wr_mode;
                ent_base[cfg_idx]  <= cfg_base;
                ent_mask[cfg_idx]  <= cfg_mask;
                ent_pe[cfg_idx]    <= cfg_pe;
                ent_shift[cfg_idx] <= wr_shift;
            end else begin
                cfg_err <= 1'b1;
            end
        end
    end

    // Per-segment endpoint lists for the individual mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) seg_pe[i] <= '0;
        end else if (cfg_seg_we) begin
            seg_pe[cfg_seg_entry][cfg_seg_num] <= cfg_seg_pe;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        pe_map_entry_match #(
            .ADDR_W(ADDR_W), .PE_COUNT(PE_COUNT), .IND_SEGS(IND_SEGS)
        ) u_match (
            .en(ent_en[g]), .mode(ent_mode[g]), .base(ent_base[g]),
            .mask(ent_mask[g]), .pe(ent_pe[g]), .shift(ent_shift[g]),
            .seg_row(seg_pe[g]), .addr(lk_addr),
            .hit(hits[g]), .pe_out(pes[g])
        );
    end

    pe_map_prio #(.ENTRIES(ENTRIES), .PE_W(PE_W)) u_prio (
        .hits(hits), .pes(pes), .any(any_hit), .pe_sel(pe_sel)
    );

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_pe    <= '1;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && any_hit;
            rsp_miss  <= lk_valid && !any_hit;
            rsp_pe    <= pe_sel;
        end
    end
endmodule

// File: rtl/pe_map_table_chk.sv
// Port-level properties of the mapping table, attached by bind.
module pe_map_table_chk #(
    parameter int PE_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_we,
    input logic            cfg_err,
    input logic            lk_valid,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic [PE_W-1:0] rsp_pe
);
    // R12: a result follows every lookup one cycle later.
    assert_rsp_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R12: no result without a lookup.
    assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    // R11: a valid result is either a hit or a miss, never both.
    assert_hit_xor_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_miss));
    // R11: a miss drives all ones.
    assert_miss_all_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_pe == {PE_W{1'b1}}));
    // R6: the error flag is sticky.
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    // R8: the error flag rises only after an entry write.
    assert_err_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(cfg_we));
endmodule

bind pe_map_table pe_map_table_chk #(.PE_W($clog2(PE_COUNT))) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_err(cfg_err),
    .lk_valid(lk_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_pe(rsp_pe)
);

// File: tb/pe_map_table_tb.sv
// Self-checking bench with an arithmetic reference model of the table.
module pe_map_table_tb;
    localparam int ADDR_W   = 64;
    localparam int PE_COUNT = 256;
    localparam int ENTRIES  = 16;
    localparam int IND_SEGS = 8;
    localparam int PE_W     = 8;
    localparam int IDX_W    = 4;
    localparam int IND_W    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic              cfg_en = 1'b0;
    logic [1:0]        cfg_mode = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [ADDR_W-1:0] cfg_mask = '0;
    logic [PE_W-1:0]   cfg_pe = '0;
    logic [1:0]        cfg_cnt_sel = '0;
    logic              cfg_seg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_seg_entry = '0;
    logic [IND_W-1:0]  cfg_seg_num = '0;
    logic [PE_W-1:0]   cfg_seg_pe = '0;
    logic              cfg_err;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              rsp_valid, rsp_hit, rsp_miss;
    logic [PE_W-1:0]   rsp_pe;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    bit              m_en   [ENTRIES];
    int              m_mode [ENTRIES];
    logic [63:0]     m_base [ENTRIES];
    logic [63:0]     m_mask [ENTRIES];
    int              m_pe   [ENTRIES];
    int              m_cnt  [ENTRIES];
    int              m_seg  [ENTRIES][IND_SEGS];
    bit              m_err;

    always #2 clk = ~clk;

    pe_map_table u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .cfg_pe(cfg_pe), .cfg_cnt_sel(cfg_cnt_sel),
        .cfg_seg_we(cfg_seg_we), .cfg_seg_entry(cfg_seg_entry),
        .cfg_seg_num(cfg_seg_num), .cfg_seg_pe(cfg_seg_pe), .cfg_err(cfg_err),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_pe(rsp_pe)
    );

    function automatic logic [63:0] win_mask(input int k);
        return (k >= 64) ? 64'd0 : ({64{1'b1}} << k);
    endfunction

    function automatic int seg_count(input int mode, input int sel);
        case (mode)
            0: return 1;
            1: return PE_COUNT;
            2: return IND_SEGS;
            default: return (sel == 0) ? 8 : (sel == 1) ? 64 : (sel == 2) ? 128 : 0;
        endcase
    endfunction

    function automatic int tz(input logic [63:0] m);
        int k = 0;
        while (k < 64 && !m[k]) k++;
        return k;
    endfunction

    function automatic bit ref_legal(input int mode, input logic [63:0] mask,
                                     input int pe, input int sel);
        int k = tz(mask);
        int cnt = seg_count(mode, sel);
        if (mask != win_mask(k)) return 0;
        if (cnt == 0) return 0;
        if ((64'd1 << k) < 64'(cnt) && k < 64) return 0;
        if (mode == 0 && k < 25) return 0;
        if (mode == 3 && (pe % cnt) != 0) return 0;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
            m_en[i] = 0;
            for (int s = 0; s < IND_SEGS; s++) m_seg[i][s] = 0;
        end
        m_err = 0;
    endtask

    task automatic wr_entry(input int idx, input bit en, input int mode,
                            input logic [63:0] base, input logic [63:0] mask,
                            input int pe, input int sel);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_en = en; cfg_mode = 2'(mode);
        cfg_base = base; cfg_mask = mask; cfg_pe = PE_W'(pe); cfg_cnt_sel = 2'(sel);
        @(negedge clk);
        cfg_we = 1'b0;
        if (!en || ref_legal(mode, mask, pe, sel)) begin
            m_en[idx] = en; m_mode[idx] = mode; m_base[idx] = base;
            m_mask[idx] = mask; m_pe[idx] = pe; m_cnt[idx] = seg_count(mode, sel);
        end else begin
            m_err = 1;
        end
    endtask

    task automatic wr_seg(input int idx, input int num, input int pe);
        cfg_seg_we = 1'b1; cfg_seg_entry = IDX_W'(idx);
        cfg_seg_num = IND_W'(num); cfg_seg_pe = PE_W'(pe);
        @(negedge clk);
        cfg_seg_we = 1'b0;
        m_seg[idx][num] = pe;
    endtask

    // Expected {hit, pe} from the model; lowest matching index wins.
    function automatic logic [8:0] ref_lookup(input logic [63:0] a);
        for (int i = 0; i < ENTRIES; i++) begin
            if (m_en[i] && ((a & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
                int k = tz(m_mask[i]);
                int lc = $clog2(m_cnt[i]);
                logic [63:0] off = a & ~m_mask[i];
                int seg = int'(off >> (k - lc));
                int pe;
                case (m_mode[i])
                    0: pe = m_pe[i];
                    1: pe = seg;
                    2: pe = m_seg[i][seg];
                    default: pe = m_pe[i] + seg;
                endcase
                return {1'b1, 8'(pe)};
            end
        end
        return {1'b0, 8'hFF};
    endfunction

    task automatic lookup(input logic [63:0] a, input string req);
        logic [8:0] e = ref_lookup(a);
        logic [10:0] exp_v = {1'b1, e[8], !e[8], e[7:0]};
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({rsp_valid, rsp_hit, rsp_miss, rsp_pe} == exp_v, req,
            64'({rsp_valid, rsp_hit, rsp_miss, rsp_pe}), 64'(exp_v));
    endtask

    task automatic chk_err(input string req);
        chk(cfg_err == m_err, req, 64'(cfg_err), 64'(m_err));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : stim
        logic [63:0] b;
        @(negedge clk);
        do_reset();
        // R13: reset state.
        chk(rsp_valid == 1'b0, "R13 rsp_valid", 64'(rsp_valid), 0);
        chk(cfg_err == 1'b0, "R13 cfg_err", 64'(cfg_err), 0);
        lookup(64'h0, "R13 R11 empty table miss");

        // R2/R1: single endpoint, 32 MiB window at the floor.
        b = 64'h0000_0001_0000_0000;
        wr_entry(3, 1, 0, b, win_mask(25), 42, 0);
        lookup(b, "R12 R2 first byte right after write");
        lookup(b + 64'h1FF_FFFF, "R2 last byte");
        lookup(b + 64'h200_0000, "R1 R11 just past window");
        lookup(b - 1, "R1 R11 just below window");
        chk_err("R7 32MiB single accepted");

        // R12: no result on an idle cycle.
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12 idle", 64'(rsp_valid), 0);

        // R3: full segmented, every segment.
        b = 64'h0000_0040_0000_0000;
        wr_entry(5, 1, 1, b, win_mask(32), 0, 0);
        for (int n = 0; n < PE_COUNT; n++)
            lookup(b + (64'(n) << 24) + 64'(n * 3), "R3 full segment");

        // R4: individual per-segment endpoints.
        b = 64'h0000_0080_0000_0000;
        wr_entry(6, 1, 2, b, win_mask(20), 0, 0);
        for (int s = 0; s < IND_SEGS; s++) wr_seg(6, s, 200 + s * 7);
        for (int s = 0; s < IND_SEGS; s++)
            lookup(b + (64'(s) << 17) + 64'h1_0000, "R4 individual segment");
        wr_seg(6, 2, 5);
        lookup(b + (64'd2 << 17), "R4 segment rewrite");

        // R5: offset mode at all three counts.
        for (int sel = 0; sel < 3; sel++) begin
            int cnt = seg_count(3, sel);
            int basepe = (sel == 0) ? 16 : (sel == 1) ? 128 : 128;
            b = 64'h0000_00C0_0000_0000 + (64'(sel) << 32);
            wr_entry(7 + sel, 1, 3, b, win_mask(30), basepe, sel);
            for (int n = 0; n < cnt; n++)
                lookup(b + (64'(n) << (30 - $clog2(cnt))), "R5 offset segment");
        end
        chk_err("R5 legal offset writes raise no error");

        // R10: overlap, lowest index wins; then disabling reveals the other.
        b = 64'h0000_0002_0000_0000;
        wr_entry(12, 1, 0, b, win_mask(25), 9, 0);
        wr_entry(2, 1, 0, b, win_mask(26), 7, 0);
        lookup(b + 64'h10, "R10 lower index wins");
        lookup(b + 64'h300_0000, "R10 only lower covers");
        wr_entry(2, 0, 0, b, 64'h1234, 0, 3);
        lookup(b + 64'h10, "R9 R1 disabled entry ignored");
        chk_err("R9 disable write with junk accepted");

        // Rejections, each from a fresh reset.
        b = 64'h0000_0010_0000_0000;
        do_reset();
        wr_entry(0, 1, 0, b, win_mask(24), 1, 0);
        chk_err("R7 16MiB single rejected");
        lookup(b, "R9 R7 entry unchanged");

        do_reset();
        wr_entry(0, 1, 3, b, win_mask(30), 20, 1);
        chk_err("R6 base not multiple rejected");
        lookup(b, "R9 R6 entry unchanged");
        wr_entry(1, 1, 0, b, win_mask(26), 3, 0);
        chk_err("R6 error stays set after legal write");
        lookup(b, "R6 legal write after reject");

        do_reset();
        wr_entry(0, 1, 0, b, win_mask(30) ^ 64'h0100_0000_0000, 1, 0);
        chk_err("R8 non-contiguous mask rejected");
        lookup(b, "R9 R8 entry unchanged");

        do_reset();
        wr_entry(0, 1, 1, b, win_mask(7), 0, 0);
        chk_err("R8 window smaller than segment count rejected");

        do_reset();
        wr_entry(0, 1, 3, b, win_mask(30), 0, 3);
        chk_err("R8 selector 3 rejected");
        lookup(b, "R9 R8 selector entry unchanged");

        summary();
        $finish;
    end
endmodule